// File: doc/BRIEF.md
# Sector Alignment Engine

This block sits between a byte-addressed transfer source and a storage port that only moves whole 512-byte sectors. A request gives a byte offset, a byte length and a direction. The block widens the request to the smallest covering run of sectors and issues one sector command for that run on the storage side. It then routes the data bytes one at a time.

On a read, every byte of the covering run is accepted from storage. Only the bytes that were asked for go to the host output stream, and the padding at either end is dropped.

On a write, any partially covered edge sector is fetched first with a one-sector read and held in a local buffer. The write stream then splices the saved edge bytes around the host bytes, so storage bytes outside the requested range are kept. A request that starts and ends on sector boundaries goes straight through. When both ragged edges fall in the same sector, that sector is fetched only once.

Top module: `sector_aligner`

## Requirements
- R1: Every command carries a sector number and count that stay stable while the command is offered and not taken. The main command has sector number = offset / 512, and count = ceil((offset mod 512 + length) / 512).
- R2: On a read, the host output carries exactly `length` bytes, equal to the storage bytes at absolute positions offset … offset+length−1 in order. The other bytes of the covering run are taken from storage and dropped.
- R3: On a write whose offset is not a multiple of 512, a one-sector read command (write flag 0, count 1) for the first covered sector comes before the write command. The written bytes of that sector below the offset equal the bytes that were fetched.
- R4: On a write whose end (offset+length) is not a multiple of 512, the last covered sector is fetched with a one-sector read. The written bytes of that sector from the end position up to the sector boundary equal the bytes that were fetched.
- R5: When the first and last covered sectors are the same and either edge is ragged, exactly one pre-read of that sector is issued.
- R6: A request with both offset and end on sector boundaries issues only the main command, with no pre-read.
- R7: `done` is a single-cycle pulse in the cycle after the last storage data byte is transferred. `busy` is high from the cycle after acceptance and is low while `done` is high.
- R8: A zero-length request raises `done` in the cycle after acceptance, issues no storage command and never raises `busy`.
- R9: A request is accepted only while `req_ready` is high, which is exactly when the block is idle. `busy` rises only after a request was offered.
- R10: On a write, exactly `length` host input bytes are consumed and exactly count×512 bytes are written. Host input is consumed only in the same cycle as a storage write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_write | input | 1 | 1 = write to storage, 0 = read from storage |
| req_offset | input | ADDR_W (32) | Byte offset of the transfer |
| req_len | input | LEN_W (16) | Byte length of the transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sto_cmd_valid | output | 1 | Sector command offered |
| sto_cmd_ready | input | 1 | Storage takes the command |
| sto_cmd_write | output | 1 | Command direction, 1 = write |
| sto_cmd_lba | output | ADDR_W−9 (23) | First sector of the command |
| sto_cmd_count | output | LEN_W−8 (8) | Number of sectors |
| sto_rd_valid | input | 1 | Storage read byte available |
| sto_rd_ready | output | 1 | Block takes the storage read byte |
| sto_rd_data | input | 8 | Storage read byte |
| sto_wr_valid | output | 1 | Storage write byte offered |
| sto_wr_ready | input | 1 | Storage takes the write byte |
| sto_wr_data | output | 8 | Storage write byte |
| host_out_valid | output | 1 | Read byte for the host |
| host_out_ready | input | 1 | Host takes the read byte |
| host_out_data | output | 8 | Read byte |
| host_in_valid | input | 1 | Host write byte available |
| host_in_ready | output | 1 | Block takes the host byte |
| host_in_data | input | 8 | Host write byte |

## Verification
The phase register moves on the accepting edge, so the first sector command is due in the cycle after acceptance. A zero-length request raises `done` in that same cycle. Data routing is combinational: a storage read byte inside the requested window shows up on the host output in the cycle it is offered, and a host byte inside the window shows up on the storage write side in its own cycle. `done` follows one cycle after the final storage data transfer.

The bench changes its inputs on the falling edge and samples one nanosecond later, before the next rising edge. At that point it logs each transfer together with a cycle number. It then compares the cycle of `done` with the cycle of the last data transfer plus one, and the cycle of `done` for a zero-length request with the acceptance cycle plus one.

// File: rtl/sector_aligner_pkg.sv
`timescale 1ns/1ps
package sector_aligner_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_PRE_CMD   = 3'd1,
    PH_PRE_DATA  = 3'd2,
    PH_MAIN_CMD  = 3'd3,
    PH_MAIN_DATA = 3'd4
  } sa_phase_e;

  // Bits of v below 2**lg (position inside a sector).
  function automatic logic [63:0] sa_low_bits(input logic [63:0] v, input int lg);
    return v & ((64'd1 << lg) - 64'd1);
  endfunction

  // Number of sectors needed to hold 'bytes' bytes that start on a boundary.
  function automatic logic [63:0] sa_sectors_spanned(input logic [63:0] bytes, input int lg);
    return (bytes + ((64'd1 << lg) - 64'd1)) >> lg;
  endfunction

endpackage

// File: rtl/sa_geom.sv
`timescale 1ns/1ps
module sa_geom
  import sector_aligner_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int SEC_LG = 9,
  parameter int LBA_W  = ADDR_W - SEC_LG,
  parameter int CNT_W  = LEN_W + 1 - SEC_LG,
  parameter int TOT_W  = LEN_W + 1
) (
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [LBA_W-1:0]  lba_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [SEC_LG-1:0] head_o,
  output logic [TOT_W-1:0]  end_o,
  output logic              zero_o,
  output logic              need_head_o,
  output logic              need_tail_o
);

  logic [SEC_LG-1:0] tail_rem;

  assign head_o   = SEC_LG'(sa_low_bits(64'(offset_i), SEC_LG));
  assign end_o    = TOT_W'(64'(head_o) + 64'(len_i));
  assign tail_rem = SEC_LG'(sa_low_bits(64'(end_o), SEC_LG));
  assign count_o  = CNT_W'(sa_sectors_spanned(64'(end_o), SEC_LG));
  assign lba_o    = LBA_W'(64'(offset_i) >> SEC_LG);
  assign zero_o   = (len_i == '0);

  // A single-sector request loads its one edge sector through the head slot.
  assign need_head_o = (head_o != '0) || ((count_o == CNT_W'(1)) && (tail_rem != '0));
  assign need_tail_o = (tail_rem != '0) && (count_o > CNT_W'(1));

endmodule

// File: rtl/sa_edge_buf.sv
`timescale 1ns/1ps
module sa_edge_buf #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int W     = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sa_route.sv
`timescale 1ns/1ps
module sa_route
  import sector_aligner_pkg::*;
#(
  parameter int SEC_LG = 9,
  parameter int TOT_W  = 17,
  parameter int BYTE_W = 8
) (
  input  sa_phase_e         phase_i,
  input  logic              write_i,
  input  logic              pre_sel_i,
  input  logic              single_i,
  input  logic [TOT_W-1:0]  idx_i,
  input  logic [SEC_LG-1:0] head_i,
  input  logic [TOT_W-1:0]  end_i,
  input  logic              sto_rd_valid_i,
  input  logic [BYTE_W-1:0] sto_rd_data_i,
  output logic              sto_rd_ready_o,
  output logic              host_out_valid_o,
  output logic [BYTE_W-1:0] host_out_data_o,
  input  logic              host_out_ready_i,
  input  logic              host_in_valid_i,
  input  logic [BYTE_W-1:0] host_in_data_i,
  output logic              host_in_ready_o,
  output logic              sto_wr_valid_o,
  output logic [BYTE_W-1:0] sto_wr_data_o,
  input  logic              sto_wr_ready_i,
  input  logic [BYTE_W-1:0] head_rd_i,
  input  logic [BYTE_W-1:0] tail_rd_i,
  output logic [1:0]        buf_we_o,
  output logic [SEC_LG-1:0] buf_addr_o,
  output logic              beat_o
);

  logic in_win;
  logic below_head;
  logic rd_take;
  logic wr_valid;

  assign below_head = idx_i < TOT_W'(head_i);
  assign in_win     = !below_head && (idx_i < end_i);
  assign buf_addr_o = idx_i[SEC_LG-1:0];
  assign host_out_data_o = sto_rd_data_i;

  always_comb begin
    sto_rd_ready_o   = 1'b0;
    host_out_valid_o = 1'b0;
    host_in_ready_o  = 1'b0;
    wr_valid         = 1'b0;
    sto_wr_data_o    = '0;
    buf_we_o         = 2'b00;
    rd_take          = 1'b0;
    beat_o           = 1'b0;
    if (phase_i == PH_PRE_DATA) begin
      sto_rd_ready_o      = 1'b1;
      buf_we_o[pre_sel_i] = sto_rd_valid_i;
      beat_o              = sto_rd_valid_i;
    end else if (phase_i == PH_MAIN_DATA && !write_i) begin
      host_out_valid_o = sto_rd_valid_i && in_win;
      rd_take          = in_win ? host_out_ready_i : 1'b1;
      sto_rd_ready_o   = rd_take;
      beat_o           = sto_rd_valid_i && rd_take;
    end else if (phase_i == PH_MAIN_DATA) begin
      if (in_win) begin
        wr_valid        = host_in_valid_i;
        host_in_ready_o = sto_wr_ready_i;
        sto_wr_data_o   = host_in_data_i;
      end else begin
        wr_valid      = 1'b1;
        sto_wr_data_o = (below_head || single_i) ? head_rd_i : tail_rd_i;
      end
      beat_o = wr_valid && sto_wr_ready_i;
    end
  end

  assign sto_wr_valid_o = wr_valid;

endmodule

// File: rtl/sa_ctrl.sv
`timescale 1ns/1ps
module sa_ctrl
  import sector_aligner_pkg::*;
#(
  parameter int SEC_LG = 9,
  parameter int LBA_W  = 23,
  parameter int CNT_W  = 8,
  parameter int TOT_W  = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [LBA_W-1:0]  geo_lba_i,
  input  logic [CNT_W-1:0]  geo_count_i,
  input  logic [SEC_LG-1:0] geo_head_i,
  input  logic [TOT_W-1:0]  geo_end_i,
  input  logic              geo_zero_i,
  input  logic              geo_need_head_i,
  input  logic              geo_need_tail_i,
  input  logic              cmd_ready_i,
  input  logic              beat_i,
  output logic              req_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cmd_valid_o,
  output logic              cmd_write_o,
  output logic [LBA_W-1:0]  cmd_lba_o,
  output logic [CNT_W-1:0]  cmd_count_o,
  output sa_phase_e         phase_o,
  output logic              write_o,
  output logic              pre_sel_o,
  output logic              single_o,
  output logic [TOT_W-1:0]  idx_o,
  output logic [SEC_LG-1:0] head_o,
  output logic [TOT_W-1:0]  end_o
);

  sa_phase_e         phase_q;
  logic              done_q, write_q, pre_sel_q, need_tail_q;
  logic [LBA_W-1:0]  lba_q;
  logic [CNT_W-1:0]  count_q;
  logic [SEC_LG-1:0] head_q;
  logic [TOT_W-1:0]  end_q, idx_q;

  // Named internal events used by the assertions below.
  logic [TOT_W-1:0] last_idx;
  logic             sector_end;
  logic             zero_accept;
  logic             final_beat;

  assign last_idx    = {count_q - 1'b1, {SEC_LG{1'b1}}};
  assign sector_end  = (idx_q[SEC_LG-1:0] == {SEC_LG{1'b1}});
  assign zero_accept = (phase_q == PH_IDLE) && req_valid_i && geo_zero_i;
  assign final_beat  = (phase_q == PH_MAIN_DATA) && beat_i && (idx_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      done_q      <= 1'b0;
      write_q     <= 1'b0;
      pre_sel_q   <= 1'b0;
      need_tail_q <= 1'b0;
      lba_q       <= '0;
      count_q     <= '0;
      head_q      <= '0;
      end_q       <= '0;
      idx_q       <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid_i) begin
            write_q     <= req_write_i;
            lba_q       <= geo_lba_i;
            count_q     <= geo_count_i;
            head_q      <= geo_head_i;
            end_q       <= geo_end_i;
            need_tail_q <= geo_need_tail_i;
            idx_q       <= '0;
            if (geo_zero_i) begin
              done_q <= 1'b1;
            end else if (req_write_i && geo_need_head_i) begin
              pre_sel_q <= 1'b0;
              phase_q   <= PH_PRE_CMD;
            end else if (req_write_i && geo_need_tail_i) begin
              pre_sel_q <= 1'b1;
              phase_q   <= PH_PRE_CMD;
            end else begin
              phase_q <= PH_MAIN_CMD;
            end
          end
        end
        PH_PRE_CMD: begin
          if (cmd_ready_i) begin
            phase_q <= PH_PRE_DATA;
            idx_q   <= '0;
          end
        end
        PH_PRE_DATA: begin
          if (beat_i) begin
            idx_q <= idx_q + 1'b1;
            if (sector_end) begin
              idx_q <= '0;
              if (!pre_sel_q && need_tail_q) begin
                pre_sel_q <= 1'b1;
                phase_q   <= PH_PRE_CMD;
              end else begin
                phase_q <= PH_MAIN_CMD;
              end
            end
          end
        end
        PH_MAIN_CMD: begin
          if (cmd_ready_i) begin
            phase_q <= PH_MAIN_DATA;
            idx_q   <= '0;
          end
        end
        PH_MAIN_DATA: begin
          if (beat_i) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == last_idx) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign req_ready_o = (phase_q == PH_IDLE);
  assign busy_o      = (phase_q != PH_IDLE);
  assign done_o      = done_q;
  assign cmd_valid_o = (phase_q == PH_PRE_CMD) || (phase_q == PH_MAIN_CMD);
  assign cmd_write_o = (phase_q == PH_MAIN_CMD) && write_q;
  assign cmd_lba_o   = (phase_q == PH_PRE_CMD && pre_sel_q)
                       ? (lba_q + LBA_W'(count_q) - 1'b1) : lba_q;
  assign cmd_count_o = (phase_q == PH_PRE_CMD) ? CNT_W'(1) : count_q;
  assign phase_o     = phase_q;
  assign write_o     = write_q;
  assign pre_sel_o   = pre_sel_q;
  assign single_o    = (count_q == CNT_W'(1));
  assign idx_o       = idx_q;
  assign head_o      = head_q;
  assign end_o       = end_q;

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
  AST_FINAL_BEAT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    final_beat |=> done_o); // R7
  AST_BUSY_AFTER_OFFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i)); // R9
  AST_ZERO_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_accept |=> (done_o && !busy_o && !cmd_valid_o)); // R8
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_lba_o) && $stable(cmd_count_o) && $stable(cmd_write_o))); // R1
  AST_PREREAD_ONE_SECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && write_q && !cmd_write_o) |-> (cmd_count_o == CNT_W'(1))); // R3

endmodule

// File: rtl/sector_aligner.sv
`timescale 1ns/1ps
module sector_aligner
  import sector_aligner_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = 32,
  parameter int LEN_W        = 16,
  parameter int BYTE_W       = 8,
  localparam int SEC_LG      = $clog2(SECTOR_BYTES),
  localparam int LBA_W       = ADDR_W - SEC_LG,
  localparam int CNT_W       = LEN_W + 1 - SEC_LG,
  localparam int TOT_W       = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic              sto_cmd_valid,
  input  logic              sto_cmd_ready,
  output logic              sto_cmd_write,
  output logic [LBA_W-1:0]  sto_cmd_lba,
  output logic [CNT_W-1:0]  sto_cmd_count,
  input  logic              sto_rd_valid,
  output logic              sto_rd_ready,
  input  logic [BYTE_W-1:0] sto_rd_data,
  output logic              sto_wr_valid,
  input  logic              sto_wr_ready,
  output logic [BYTE_W-1:0] sto_wr_data,
  output logic              host_out_valid,
  input  logic              host_out_ready,
  output logic [BYTE_W-1:0] host_out_data,
  input  logic              host_in_valid,
  output logic              host_in_ready,
  input  logic [BYTE_W-1:0] host_in_data
);

  logic [LBA_W-1:0]  geo_lba;
  logic [CNT_W-1:0]  geo_count;
  logic [SEC_LG-1:0] geo_head;
  logic [TOT_W-1:0]  geo_end;
  logic              geo_zero, geo_need_head, geo_need_tail;

  sa_phase_e         phase;
  logic              cur_write, pre_sel, single, beat;
  logic [TOT_W-1:0]  idx, cur_end;
  logic [SEC_LG-1:0] cur_head, buf_addr;
  logic [1:0]        buf_we;
  logic [BYTE_W-1:0] buf_rd [2];

  sa_geom #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEC_LG(SEC_LG),
            .LBA_W(LBA_W), .CNT_W(CNT_W), .TOT_W(TOT_W)) geom_i (
    .offset_i(req_offset), .len_i(req_len),
    .lba_o(geo_lba), .count_o(geo_count), .head_o(geo_head), .end_o(geo_end),
    .zero_o(geo_zero), .need_head_o(geo_need_head), .need_tail_o(geo_need_tail)
  );

  sa_ctrl #(.SEC_LG(SEC_LG), .LBA_W(LBA_W), .CNT_W(CNT_W), .TOT_W(TOT_W)) ctrl_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .geo_lba_i(geo_lba), .geo_count_i(geo_count), .geo_head_i(geo_head),
    .geo_end_i(geo_end), .geo_zero_i(geo_zero),
    .geo_need_head_i(geo_need_head), .geo_need_tail_i(geo_need_tail),
    .cmd_ready_i(sto_cmd_ready), .beat_i(beat),
    .req_ready_o(req_ready), .busy_o(busy), .done_o(done),
    .cmd_valid_o(sto_cmd_valid), .cmd_write_o(sto_cmd_write),
    .cmd_lba_o(sto_cmd_lba), .cmd_count_o(sto_cmd_count),
    .phase_o(phase), .write_o(cur_write), .pre_sel_o(pre_sel), .single_o(single),
    .idx_o(idx), .head_o(cur_head), .end_o(cur_end)
  );

  // Slot 0 holds the first covered sector, slot 1 the last one.
  for (genvar g = 0; g < 2; g++) begin : g_edge
    sa_edge_buf #(.DEPTH(SECTOR_BYTES), .AW(SEC_LG), .W(BYTE_W)) buf_i (
      .clk_i(clk), .we_i(buf_we[g]), .waddr_i(buf_addr), .wdata_i(sto_rd_data),
      .raddr_i(buf_addr), .rdata_o(buf_rd[g])
    );
  end

  sa_route #(.SEC_LG(SEC_LG), .TOT_W(TOT_W), .BYTE_W(BYTE_W)) route_i (
    .phase_i(phase), .write_i(cur_write), .pre_sel_i(pre_sel), .single_i(single),
    .idx_i(idx), .head_i(cur_head), .end_i(cur_end),
    .sto_rd_valid_i(sto_rd_valid), .sto_rd_data_i(sto_rd_data), .sto_rd_ready_o(sto_rd_ready),
    .host_out_valid_o(host_out_valid), .host_out_data_o(host_out_data),
    .host_out_ready_i(host_out_ready),
    .host_in_valid_i(host_in_valid), .host_in_data_i(host_in_data),
    .host_in_ready_o(host_in_ready),
    .sto_wr_valid_o(sto_wr_valid), .sto_wr_data_o(sto_wr_data), .sto_wr_ready_i(sto_wr_ready),
    .head_rd_i(buf_rd[0]), .tail_rd_i(buf_rd[1]),
    .buf_we_o(buf_we), .buf_addr_o(buf_addr), .beat_o(beat)
  );

  AST_OUT_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_out_valid |-> (busy && !sto_wr_valid)); // R2
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sto_wr_valid |-> busy); // R10
  AST_HOST_IN_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_in_valid && host_in_ready) |-> (sto_wr_valid && sto_wr_ready)); // R10

endmodule

// File: tb/sector_aligner_tb_top.sv
`timescale 1ns/1ps
module sector_aligner_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_offset = '0;
  logic [15:0] req_len = '0;
  logic        req_ready, busy, done;
  logic        sto_cmd_valid, sto_cmd_write;
  logic        sto_cmd_ready = 1'b0;
  logic [22:0] sto_cmd_lba;
  logic [7:0]  sto_cmd_count;
  logic        sto_rd_valid = 1'b0, sto_rd_ready;
  logic [7:0]  sto_rd_data = '0;
  logic        sto_wr_valid, sto_wr_ready = 1'b0;
  logic [7:0]  sto_wr_data;
  logic        host_out_valid, host_out_ready = 1'b0;
  logic [7:0]  host_out_data;
  logic        host_in_valid = 1'b0, host_in_ready;
  logic [7:0]  host_in_data = '0;

  sector_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_len(req_len),
    .busy(busy), .done(done),
    .sto_cmd_valid(sto_cmd_valid), .sto_cmd_ready(sto_cmd_ready),
    .sto_cmd_write(sto_cmd_write), .sto_cmd_lba(sto_cmd_lba), .sto_cmd_count(sto_cmd_count),
    .sto_rd_valid(sto_rd_valid), .sto_rd_ready(sto_rd_ready), .sto_rd_data(sto_rd_data),
    .sto_wr_valid(sto_wr_valid), .sto_wr_ready(sto_wr_ready), .sto_wr_data(sto_wr_data),
    .host_out_valid(host_out_valid), .host_out_ready(host_out_ready), .host_out_data(host_out_data),
    .host_in_valid(host_in_valid), .host_in_ready(host_in_ready), .host_in_data(host_in_data)
  );

  always #2 clk = ~clk;   // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  // Storage contents and host write pattern, as functions of position.
  function automatic logic [7:0] stor_byte(input int a);
    return 8'(a * 29 + (a >> 9) * 7 + 3);
  endfunction
  function automatic logic [7:0] host_byte(input int i);
    return 8'(i * 13 + 101);
  endfunction

  // Current request context (written by the scenario tasks only).
  int cur_off = 0, cur_len = 0, in_base = 0, out_base = 0;

  // Monitor state (written by the monitor only).
  int n_cmd = 0;
  int log_w [64];
  int log_lba [64];
  int log_cnt [64];
  int rd_rem = 0, rd_addr = 0, wr_addr = 0, wr_bytes = 0;
  int in_idx = 0, out_cnt = 0, mism = 0, done_cnt = 0, busy_cnt = 0;
  int done_cyc = 0, last_data_cyc = 0;
  int first_act = 0, first_exp = 0;

  initial begin : storage_and_host_model
    forever begin
      @(negedge clk);
      sto_rd_valid   = (rd_rem > 0) && (cyc % 7 != 3);
      sto_rd_data    = stor_byte(rd_addr);
      sto_cmd_ready  = (cyc % 4 != 0);
      sto_wr_ready   = (cyc % 6 != 1);
      host_out_ready = (cyc % 5 != 2);
      host_in_valid  = 1'b1;
      host_in_data   = host_byte(in_idx - in_base);
      #1;
      if (rst_n) begin
        if (busy) busy_cnt++;
        if (done) begin done_cnt++; done_cyc = cyc; end
        if (sto_cmd_valid && sto_cmd_ready) begin
          if (n_cmd < 64) begin
            log_w[n_cmd] = int'(sto_cmd_write);
            log_lba[n_cmd] = int'(sto_cmd_lba);
            log_cnt[n_cmd] = int'(sto_cmd_count);
          end
          n_cmd++;
          if (sto_cmd_write) wr_addr = int'(sto_cmd_lba) * 512;
          else begin
            rd_addr = int'(sto_cmd_lba) * 512;
            rd_rem  = int'(sto_cmd_count) * 512;
          end
        end
        if (sto_rd_valid && sto_rd_ready) begin
          rd_addr++; rd_rem--; last_data_cyc = cyc;
        end
        if (host_out_valid && host_out_ready) begin
          if (host_out_data !== stor_byte(cur_off + out_cnt - out_base)) begin
            if (mism == 0) begin
              first_act = int'(host_out_data);
              first_exp = int'(stor_byte(cur_off + out_cnt - out_base));
            end
            mism++;
          end
          out_cnt++;
        end
        if (sto_wr_valid && sto_wr_ready) begin
          logic [7:0] e;
          if (wr_addr >= cur_off && wr_addr < cur_off + cur_len) e = host_byte(wr_addr - cur_off);
          else e = stor_byte(wr_addr);
          if (sto_wr_data !== e) begin
            if (mism == 0) begin first_act = int'(sto_wr_data); first_exp = int'(e); end
            mism++;
          end
          wr_addr++; wr_bytes++; last_data_cyc = cyc;
        end
        if (host_in_valid && host_in_ready) in_idx++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Offers one request and returns the cycle of its acceptance.
  task automatic offer(input bit wr, input int off, input int len, output int acc_cyc);
    @(negedge clk);
    cur_off = off; cur_len = len; in_base = in_idx; out_base = out_cnt;
    req_valid = 1'b1; req_write = wr; req_offset = off; req_len = 16'(len);
    forever begin
      #1.5;
      if (req_ready) break;
      @(negedge clk);
    end
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int done0);
    int guard = 0;
    while (done_cnt == done0 && guard < 40000) begin
      @(negedge clk); guard++;
    end
    chk(guard < 40000, "R7", "watchdog: done never seen", guard, 0);
    @(negedge clk); #1.5;   // let a stray second pulse be counted
  endtask

  // Directed transfer scenario with independently computed expectations.
  task automatic run_case(input bit wr, input int off, input int len, input string req_tag);
    int first_s, last_s, cnt, h, t, acc;
    int n_exp;
    int ew [4];
    int el [4];
    int ec [4];
    int cmd0, done0, mism0, wr0, in0, out0;
    first_s = off / 512; last_s = (off + len - 1) / 512; cnt = last_s - first_s + 1;
    h = off % 512; t = (off + len) % 512;
    n_exp = 0;
    if (wr) begin
      if (first_s == last_s) begin
        if (h != 0 || t != 0) begin ew[n_exp] = 0; el[n_exp] = first_s; ec[n_exp] = 1; n_exp++; end
      end else begin
        if (h != 0) begin ew[n_exp] = 0; el[n_exp] = first_s; ec[n_exp] = 1; n_exp++; end
        if (t != 0) begin ew[n_exp] = 0; el[n_exp] = last_s; ec[n_exp] = 1; n_exp++; end
      end
    end
    ew[n_exp] = int'(wr); el[n_exp] = first_s; ec[n_exp] = cnt; n_exp++;
    cmd0 = n_cmd; done0 = done_cnt; mism0 = mism; wr0 = wr_bytes; in0 = in_idx; out0 = out_cnt;

    offer(wr, off, len, acc);
    #1.5;
    chk(busy === 1'b1, "R7", "busy in cycle after acceptance", int'(busy), 1);
    wait_done(done0);

    chk(n_cmd - cmd0 == n_exp, req_tag, "command count (pre-reads + main)", n_cmd - cmd0, n_exp);
    for (int i = 0; i < n_exp && i < n_cmd - cmd0; i++) begin
      chk(log_w[cmd0+i] == ew[i] && log_lba[cmd0+i] == el[i] && log_cnt[cmd0+i] == ec[i],
          "R1", $sformatf("command %0d lba (w=%0d cnt=%0d)", i, log_w[cmd0+i], log_cnt[cmd0+i]),
          log_lba[cmd0+i], el[i]);
    end
    chk(mism == mism0, wr ? "R4" : "R2", "first mismatching data byte", first_act, first_exp);
    if (wr) begin
      chk(in_idx - in0 == len, "R10", "host bytes consumed", in_idx - in0, len);
      chk(wr_bytes - wr0 == cnt * 512, "R10", "bytes written to storage", wr_bytes - wr0, cnt * 512);
    end else begin
      chk(out_cnt - out0 == len, "R2", "bytes delivered to host", out_cnt - out0, len);
      chk(rd_rem == 0, "R2", "storage bytes left untaken", rd_rem, 0);
    end
    chk(done_cnt - done0 == 1, "R7", "done pulses per request", done_cnt - done0, 1);
    chk(done_cyc == last_data_cyc + 1, "R7", "done cycle vs last data cycle + 1", done_cyc, last_data_cyc + 1);
    chk(busy === 1'b0 && req_ready === 1'b1, "R9", "idle and ready after done", int'(busy), 0);
  endtask

  task automatic run_zero(input int off);
    int acc, cmd0, done0, busy0;
    cmd0 = n_cmd; done0 = done_cnt; busy0 = busy_cnt;
    offer(1'b1, off, 0, acc);
    #1.5;
    repeat (4) @(negedge clk);
    #1.5;
    chk(done_cnt - done0 == 1, "R8", "zero-length done pulses", done_cnt - done0, 1);
    chk(done_cyc == acc + 1, "R8", "zero-length done cycle", done_cyc, acc + 1);
    chk(n_cmd == cmd0, "R8", "zero-length storage commands", n_cmd - cmd0, 0);
    chk(busy_cnt == busy0, "R8", "zero-length busy cycles", busy_cnt - busy0, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired (R7) actual=%0d expected=%0d", 190000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1.5;
    chk(busy === 1'b0 && done === 1'b0, "R7", "reset: busy/done low", int'(busy) + int'(done), 0);
    chk(req_ready === 1'b1, "R9", "reset: ready high", int'(req_ready), 1);
    chk(sto_cmd_valid === 1'b0 && sto_wr_valid === 1'b0 && host_out_valid === 1'b0,
        "R10", "reset: no traffic offered", int'(sto_cmd_valid), 0);

    run_case(1'b0, 1024, 1024, "R6");   // aligned read
    run_case(1'b0, 700,  900,  "R2");   // ragged both edges, 3 sectors
    run_case(1'b0, 10,   20,   "R2");   // inside a single sector
    run_case(1'b1, 512,  512,  "R6");   // aligned write, no pre-read
    run_case(1'b1, 1000, 1500, "R3");   // ragged both edges, two pre-reads
    run_case(1'b1, 2060, 100,  "R5");   // both edges in one sector
    run_case(1'b1, 100,  924,  "R3");   // ragged head only
    run_case(1'b1, 1536, 600,  "R4");   // ragged tail only
    run_case(1'b1, 512,  10,   "R5");   // tail-only inside one sector
    run_zero(777);                      // zero length
    run_case(1'b0, 511,  2,    "R2");   // straddles a boundary

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule